// File: doc/BRIEF.md
# Motor current and bus-voltage scaler

This block turns the three raw 16-bit results of an analog-to-digital converter into calibrated signed Q15 numbers for a motor drive. The three results are two phase currents, A and B, and the DC-bus voltage. The block also rebuilds the third phase current from the other two. A controller pulses `start`. The block then watches the converter status word and waits while the sequencer busy bit is set. Once that bit clears, the block fetches the three results one per cycle through a select/data read port, in a fixed order.

For each channel, the raw code is first converted to a signed Q15 sample. The current channels use a bipolar conversion and the bus-voltage channel uses a unipolar one. The sample is multiplied by a Q13 gain, a Q15 offset aligned to Q28 is added, and the 32-bit accumulation saturates. The current channels are then negated, so that a positive value means current flowing toward the motor. The Q15 result is the accumulator shifted right by 13 and clamped. Phase C is the clamped negative sum of the final A and B values.

All four outputs change in the same cycle, and a one-cycle `valid_o` strobe marks that cycle. The six calibration words sit in registers loaded through a small address/data write port.

Top module: `mcs_scaler`

## Requirements
- R1: After reset, all four outputs and all six calibration registers read as zero and `valid_o` is low. A run made with no calibration writes therefore yields zero on every output.
- R2: A write with `cfg_we` high stores `cfg_wdata` at `cfg_addr`. The address map is: 0 gain A, 1 offset A, 2 gain B, 3 offset B, 4 gain V, 5 offset V. Writes to addresses 6 and 7 change nothing.
- R3: After `start`, no result is fetched while bit 12 of `adc_stat` is set. All other status bits are ignored.
- R4: Results are fetched with `res_sel` = 0 (phase A), then 1 (phase B), then 2 (bus voltage), on consecutive cycles. If bit 12 is seen clear at clock edge W, `valid_o` is high in the cycle after edge W+4. The earliest W is the edge after the one that captured `start`.
- R5: Each current sample is the raw code with bit 15 inverted, read as a signed 16-bit number.
- R6: The bus-voltage sample is the raw code shifted right by one with bit 15 forced to zero, so the sample is never negative.
- R7: Each channel forms gain×sample + offset×2^13 in a 32-bit accumulator that saturates on overflow. The channel's Q15 value is the accumulator arithmetically shifted right by 13 and clamped to −32768..32767.
- R8: The two current channels negate their saturated accumulator before the shift, again with saturation. The bus-voltage channel is not negated.
- R9: `ic_o` equals −(`ia_o` + `ib_o`) computed on the new values, clamped to −32768..32767.
- R10: `valid_o` is high for exactly one cycle per run. All four outputs take their new values in that cycle and hold them in every other cycle.
- R11: A `start` pulse that arrives while a run is in progress has no effect: it produces no extra strobe and does not change the strobe timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Single-cycle request for a new measurement run |
| adc_stat | input | 16 | Converter status word; bit 12 set means the sequencer is busy |
| res_sel | output | 2 | Result index being fetched: 0 phase A, 1 phase B, 2 bus voltage |
| res_data | input | 16 | Raw unsigned result for the selected index, valid in the same cycle |
| cfg_we | input | 1 | Calibration write enable |
| cfg_addr | input | 3 | Calibration register address |
| cfg_wdata | input | 16 | Calibration write data (signed) |
| ia_o | output | 16 | Phase A current, signed Q15 |
| ib_o | output | 16 | Phase B current, signed Q15 |
| ic_o | output | 16 | Derived phase C current, signed Q15 |
| vdc_o | output | 16 | Bus voltage, signed Q15 |
| valid_o | output | 1 | One-cycle strobe when the four outputs update |

## Verification
Some properties are asserted on every cycle: the sequencer stays in its wait state while the busy bit is set, the channels are fetched A then B then voltage, the strobe lasts a single cycle, and the four outputs do not move outside the strobe cycle. The arithmetic can only be shown by the bench's scenarios, because its checks compare against a model computed independently. Those scenarios cover the bipolar and unipolar conversions, the sign inversion, the clamping of a channel and of the derived phase, the exact strobe delay after the busy bit drops, writes to unmapped addresses, and `start` pulses sent during a run.

// File: rtl/mcs_pkg.sv
package mcs_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT,
    ST_CHA,
    ST_CHB,
    ST_CHV,
    ST_PUB
  } mcs_state_t;

  localparam int unsigned NCH = 3;
  localparam logic [1:0] SEL_A = 2'd0;
  localparam logic [1:0] SEL_B = 2'd1;
  localparam logic [1:0] SEL_V = 2'd2;
endpackage

// File: rtl/mcs_cfg_regs.sv
module mcs_cfg_regs #(
  parameter int DW  = 16,
  parameter int NCH = 3,
  parameter int CAW = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cfg_we,
  input  logic [CAW-1:0]           cfg_addr,
  input  logic [DW-1:0]            cfg_wdata,
  output logic [NCH-1:0][DW-1:0]   gain_o,
  output logic [NCH-1:0][DW-1:0]   offs_o
);
  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    logic gain_en;
    logic offs_en;
    assign gain_en = cfg_we && (cfg_addr == CAW'(2*ch));
    assign offs_en = cfg_we && (cfg_addr == CAW'(2*ch + 1));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        gain_o[ch] <= '0;
      end else if (gain_en) begin
        gain_o[ch] <= cfg_wdata;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        offs_o[ch] <= '0;
      end else if (offs_en) begin
        offs_o[ch] <= cfg_wdata;
      end
    end
  end
endmodule

// File: rtl/mcs_chan_scale.sv
module mcs_chan_scale #(
  parameter int DW = 16,
  parameter int GQ = 13,
  parameter int AW = 32
) (
  input  logic               [DW-1:0] raw,
  input  logic signed        [DW-1:0] gain,
  input  logic signed        [DW-1:0] offs,
  input  logic                        bipolar,
  output logic signed        [DW-1:0] q
);
  localparam int PW = 2 * DW;
  localparam logic signed [AW-1:0] QMAX = {{(AW-DW+1){1'b0}}, {(DW-1){1'b1}}};
  localparam logic signed [AW-1:0] QMIN = {{(AW-DW+1){1'b1}}, {(DW-1){1'b0}}};
  localparam logic signed [AW-1:0] AMAX = {1'b0, {(AW-1){1'b1}}};
  localparam logic signed [AW-1:0] AMIN = {1'b1, {(AW-1){1'b0}}};

  logic signed [DW-1:0] smp;
  logic signed [PW-1:0] prod;
  logic signed [AW:0]   offx;
  logic signed [AW:0]   sum;
  logic signed [AW:0]   nsum;
  logic signed [AW-1:0] acc;
  logic signed [AW-1:0] nacc;
  logic signed [AW-1:0] pick;
  logic signed [AW-1:0] shft;

  always_comb begin
    // bipolar: flip the sign bit; unipolar: halve and keep non-negative
    if (bipolar) begin
      smp = $signed(raw ^ {1'b1, {(DW-1){1'b0}}});
    end else begin
      smp = $signed({1'b0, raw[DW-1:1]});
    end
    prod = PW'(smp) * PW'(gain);
    offx = (AW+1)'(offs) <<< GQ;
    sum  = (AW+1)'(prod) + offx;
    if (sum[AW] != sum[AW-1]) begin
      acc = sum[AW] ? AMIN : AMAX;
    end else begin
      acc = sum[AW-1:0];
    end
    nsum = -((AW+1)'(acc));
    if (nsum[AW] != nsum[AW-1]) begin
      nacc = nsum[AW] ? AMIN : AMAX;
    end else begin
      nacc = nsum[AW-1:0];
    end
    pick = bipolar ? nacc : acc;
    shft = pick >>> GQ;
    if (shft > QMAX) begin
      q = QMAX[DW-1:0];
    end else if (shft < QMIN) begin
      q = QMIN[DW-1:0];
    end else begin
      q = shft[DW-1:0];
    end
  end
endmodule

// File: rtl/mcs_seq.sv
module mcs_seq
  import mcs_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       busy,
  output logic [1:0] sel,
  output logic       ld,
  output logic       pub
);
  mcs_state_t st_q;
  mcs_state_t st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (start) st_d = ST_WAIT;
      ST_WAIT: if (!busy) st_d = ST_CHA;
      ST_CHA:  st_d = ST_CHB;
      ST_CHB:  st_d = ST_CHV;
      ST_CHV:  st_d = ST_PUB;
      ST_PUB:  st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;
    end else begin
      st_q <= st_d;
    end
  end

  always_comb begin
    sel = SEL_A;
    ld  = 1'b0;
    pub = 1'b0;
    unique case (st_q)
      ST_CHA: begin sel = SEL_A; ld = 1'b1; end
      ST_CHB: begin sel = SEL_B; ld = 1'b1; end
      ST_CHV: begin sel = SEL_V; ld = 1'b1; end
      ST_PUB: pub = 1'b1;
      default: ;
    endcase
  end

  // R3
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_WAIT && busy) |=> (st_q == ST_WAIT));

  // R4
  order_ab_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_CHA) |=> (st_q == ST_CHB));

  // R4
  order_bv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_CHB) |=> (st_q == ST_CHV));
endmodule

// File: rtl/mcs_scaler.sv
module mcs_scaler
  import mcs_pkg::*;
#(
  parameter int DW       = 16,
  parameter int GQ       = 13,
  parameter int AW       = 32,
  parameter int SW       = 16,
  parameter int BUSY_BIT = 12,
  localparam int CAW     = $clog2(2 * NCH)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [SW-1:0]  adc_stat,
  output logic [1:0]     res_sel,
  input  logic [DW-1:0]  res_data,
  input  logic           cfg_we,
  input  logic [CAW-1:0] cfg_addr,
  input  logic [DW-1:0]  cfg_wdata,
  output logic [DW-1:0]  ia_o,
  output logic [DW-1:0]  ib_o,
  output logic [DW-1:0]  ic_o,
  output logic [DW-1:0]  vdc_o,
  output logic           valid_o
);
  localparam logic signed [DW+1:0] CMAX = {3'b000, {(DW-1){1'b1}}};
  localparam logic signed [DW+1:0] CMIN = {3'b111, {(DW-1){1'b0}}};

  // reset: asserted at once, released after two clock edges
  logic [1:0] rs_q;
  logic       rst_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_q <= 2'b00;
    end else begin
      rs_q <= {rs_q[0], 1'b1};
    end
  end
  assign rst_s = rs_q[1];

  logic busy;
  logic stat_unused;
  assign busy        = adc_stat[BUSY_BIT];
  assign stat_unused = ^adc_stat;

  logic [NCH-1:0][DW-1:0] gain;
  logic [NCH-1:0][DW-1:0] offs;

  mcs_cfg_regs #(.DW(DW), .NCH(NCH), .CAW(CAW)) u_cfg (
    .clk      (clk),
    .rst_n    (rst_s),
    .cfg_we   (cfg_we),
    .cfg_addr (cfg_addr),
    .cfg_wdata(cfg_wdata),
    .gain_o   (gain),
    .offs_o   (offs)
  );

  logic [1:0] sel;
  logic       ld;
  logic       pub;

  mcs_seq u_seq (
    .clk  (clk),
    .rst_n(rst_s),
    .start(start),
    .busy (busy),
    .sel  (sel),
    .ld   (ld),
    .pub  (pub)
  );
  assign res_sel = sel;

  logic signed [DW-1:0] g_cur;
  logic signed [DW-1:0] o_cur;
  logic                 bip_cur;
  logic signed [DW-1:0] q_cur;

  always_comb begin
    unique case (sel)
      SEL_B:   begin g_cur = gain[1]; o_cur = offs[1]; end
      SEL_V:   begin g_cur = gain[2]; o_cur = offs[2]; end
      default: begin g_cur = gain[0]; o_cur = offs[0]; end
    endcase
    bip_cur = (sel != SEL_V);
  end

  mcs_chan_scale #(.DW(DW), .GQ(GQ), .AW(AW)) u_scale (
    .raw    (res_data),
    .gain   (g_cur),
    .offs   (o_cur),
    .bipolar(bip_cur),
    .q      (q_cur)
  );

  logic [NCH-1:0][DW-1:0] stage_q;
  for (genvar ch = 0; ch < NCH; ch++) begin : g_stage
    logic st_en;
    assign st_en = ld && (sel == 2'(ch));
    always_ff @(posedge clk or negedge rst_s) begin
      if (!rst_s) begin
        stage_q[ch] <= '0;
      end else if (st_en) begin
        stage_q[ch] <= q_cur;
      end
    end
  end

  logic signed [DW+1:0] csum;
  logic signed [DW-1:0] c_d;
  always_comb begin
    csum = -((DW+2)'($signed(stage_q[0])) + (DW+2)'($signed(stage_q[1])));
    if (csum > CMAX) begin
      c_d = CMAX[DW-1:0];
    end else if (csum < CMIN) begin
      c_d = CMIN[DW-1:0];
    end else begin
      c_d = csum[DW-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      ia_o  <= '0;
      ib_o  <= '0;
      vdc_o <= '0;
      ic_o  <= '0;
    end else if (pub) begin
      ia_o  <= stage_q[0];
      ib_o  <= stage_q[1];
      vdc_o <= stage_q[2];
      ic_o  <= c_d;
    end
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      valid_o <= 1'b0;
    end else begin
      valid_o <= pub;
    end
  end

  // R10
  strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_s)
    valid_o |=> !valid_o);

  // R10
  outputs_hold_chk: assert property (@(posedge clk) disable iff (!rst_s)
    !valid_o |-> $stable({ia_o, ib_o, ic_o, vdc_o}));
endmodule

// File: tb/mcs_scaler_test.sv
module mcs_scaler_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        busy = 1'b0;
  logic [15:0] noise = 16'hEFFF;
  logic [15:0] adc_stat;
  logic [1:0]  res_sel;
  logic [15:0] res_data;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_addr = '0;
  logic [15:0] cfg_wdata = '0;
  logic [15:0] ia_o, ib_o, ic_o, vdc_o;
  logic        valid_o;

  always #4 clk = ~clk;

  int raw_a, raw_b, raw_v;
  assign adc_stat = busy ? (noise | 16'h1000) : (noise & 16'hEFFF);
  always_comb begin
    case (res_sel)
      2'd0:    res_data = 16'(raw_a);
      2'd1:    res_data = 16'(raw_b);
      2'd2:    res_data = 16'(raw_v);
      default: res_data = 16'hDEAD;
    endcase
  end

  mcs_scaler uut (
    .clk(clk), .rst_n(rst_n), .start(start), .adc_stat(adc_stat),
    .res_sel(res_sel), .res_data(res_data), .cfg_we(cfg_we),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .ia_o(ia_o), .ib_o(ib_o),
    .ic_o(ic_o), .vdc_o(vdc_o), .valid_o(valid_o)
  );

  int    checks = 0;
  int    errors = 0;
  bit    done = 0;
  int    cyc = 0;
  int    vcyc = -1;
  int    pg[6];
  int    e_a = 0, e_b = 0, e_c = 0, e_v = 0;
  int    p_a, p_b, p_c, p_v;
  string cur_tag = "R1";

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  function automatic longint sat32(longint x);
    if (x > 64'sd2147483647) return 64'sd2147483647;
    if (x < -64'sd2147483648) return -64'sd2147483648;
    return x;
  endfunction

  function automatic int clamp16(longint x);
    if (x > 32767) return 32767;
    if (x < -32768) return -32768;
    return int'(x);
  endfunction

  function automatic int scl(int raw, int g, int o, bit bip);
    longint s, a;
    if (bip) begin
      s = longint'(raw ^ 32'h8000);
      if (s > 32767) s -= 65536;
    end else begin
      s = longint'(raw >> 1);
    end
    a = sat32(s * g + longint'(o) * 8192);
    if (bip) a = sat32(-a);
    a = a >>> 13;
    return clamp16(a);
  endfunction

  // one clock of the reference model, compared at the falling edge
  task automatic step();
    bit ev;
    @(negedge clk);
    cyc++;
    ev = (cyc == vcyc);
    if (ev) begin
      e_a = p_a; e_b = p_b; e_c = p_c; e_v = p_v;
    end
    chk("R10 strobe", int'(valid_o), int'(ev));
    chk(cur_tag, int'($signed(ia_o)), e_a);
    chk(cur_tag, int'($signed(ib_o)), e_b);
    chk(cur_tag, int'($signed(ic_o)), e_c);
    chk(cur_tag, int'($signed(vdc_o)), e_v);
  endtask

  task automatic wr(int addr, int data);
    step();
    cfg_we = 1'b1; cfg_addr = 3'(addr); cfg_wdata = 16'(data);
    if (addr < 6) pg[addr] = data;
    step();
    cfg_we = 1'b0;
  endtask

  task automatic run(int ra, int rb, int rv, int nb, bit restart, string tag);
    int n;
    step();
    n = cyc;
    cur_tag = tag;
    raw_a = ra; raw_b = rb; raw_v = rv;
    start = 1'b1;
    busy = (nb > 0);
    p_a = scl(ra, pg[0], pg[1], 1'b1);
    p_b = scl(rb, pg[2], pg[3], 1'b1);
    p_v = scl(rv, pg[4], pg[5], 1'b0);
    p_c = clamp16(-(longint'(p_a) + longint'(p_b)));
    vcyc = n + ((nb > 1) ? nb : 1) + 5;
    while (cyc < vcyc) begin
      step();
      start = restart && (cyc == n + 2);
      if (cyc >= n + nb) busy = 1'b0;
    end
    chk({tag, " ia"}, int'($signed(ia_o)), p_a);
    chk({tag, " vdc"}, int'($signed(vdc_o)), p_v);
    chk("R9 ic", int'($signed(ic_o)), p_c);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got hang expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    foreach (pg[i]) pg[i] = 0;
    raw_a = 0; raw_b = 0; raw_v = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cur_tag = "R1";
    repeat (3) step();
    chk("R1 reset valid", int'(valid_o), 0);
    // R1: parameters start at zero, so every output stays zero
    run(16'hC000, 16'h1234, 16'hFFFF, 0, 0, "R1");
    // R5 R8: unit gain, bipolar conversion and sign inversion
    wr(0, 8192); wr(2, 8192); wr(4, 8192);
    run(16'hC000, 16'h4000, 16'hFFFF, 0, 0, "R5");
    chk("R8 ib inverted", int'($signed(ib_o)), 16384);
    chk("R6 vdc full scale", int'($signed(vdc_o)), 32767);
    // R6: unipolar conversion with offsets applied
    wr(1, -1000); wr(3, 500); wr(5, 2000);
    run(16'h8001, 16'h7FFF, 16'h0003, 2, 0, "R6");
    // R7 R9: clamp of a channel and of the derived phase
    wr(0, -32768); wr(1, 32767); wr(2, -32768); wr(3, 32767);
    run(16'h0000, 16'h0000, 16'h8000, 1, 0, "R7");
    chk("R9 ic clamp high", int'($signed(ic_o)), 32767);
    wr(0, 32767); wr(1, -32768); wr(2, 32767); wr(3, -32768);
    run(16'h0000, 16'h0000, 16'h1000, 0, 0, "R7");
    chk("R7 ia clamp high", int'($signed(ia_o)), 32767);
    // R3 R11: long busy with unrelated status bits, extra start mid-run
    noise = 16'hEFFF;
    run(16'h9000, 16'h6000, 16'h5555, 7, 1, "R3");
    run(16'h7000, 16'hA000, 16'h2222, 0, 1, "R11");
    noise = 16'h0000;
    // R2: writes to unmapped addresses leave results unchanged
    wr(6, 16'h1111); wr(7, -5);
    run(16'h7000, 16'hA000, 16'h2222, 3, 0, "R2");
    // R4: mixed patterns and busy lengths
    for (int k = 0; k < 12; k++) begin
      for (int r = 0; r < 6; r++) wr(r, int'($urandom_range(0, 65535)) - 32768);
      run(int'($urandom_range(0, 65535)), int'($urandom_range(0, 65535)),
          int'($urandom_range(0, 65535)), int'($urandom_range(0, 4)), k[0], "R4");
    end
    repeat (3) step();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule